// File: doc/BRIEF.md
# Selectable single/double edge parallel nibble capture

This block takes a 4-bit parallel transmit bus and delivers it as a stream of captured nibbles in the domain of the bus clock. It supports two sampling schemes. In single-rate mode the bus is sampled once per clock, on the rising edge, so the clock runs at the word rate. In double-rate mode the clock runs at half the word rate and the bus is sampled on both edges. The nibble taken on a rising edge and the nibble taken on the falling edge that follows it leave the block together as an ordered pair. The first output lane holds the rising-edge nibble and has its own strobe. The second lane holds the falling-edge nibble and has its own strobe.

The mode is resolved separately for three parallel clocks: receive, transmit input and transmit output. With the source select low, one global pin puts all three clocks in the same mode. With the source select high, each clock takes its mode from its own enable bit. The resolved modes are latched only while the block is held in synchronous reset, so a mode change never splits a nibble pair. Only the transmit-input mode decides how this block samples its bus. The other two modes are brought out for neighbouring logic. A swap control can reverse the bit order of every captured nibble before it reaches the output register.

Control is a small state machine with three states. HOLD is the reset state: no strobes are raised and the modes are latched. SINGLE and DOUBLE are the running states, one for each sampling scheme. The transition HOLD→SINGLE is taken on the first clock edge with reset low when the latched transmit-input mode is single-rate. The transition HOLD→DOUBLE is taken on that edge when the mode is double-rate. Asserting reset from either running state returns the machine to HOLD. No other transitions exist.

Top module: `sdr_ddr_capture`

## Requirements
- R1: While `rst` is sampled high on a rising edge, both `vld_a` and `vld_b` are 0 after that edge.
- R2: With `use_reg`=0, every bit of `clk_ddr` equals `pin_ddr` after reset. The bit order is bit 0 receive, bit 1 transmit input, bit 2 transmit output, and 1 means double-rate.
- R3: With `use_reg`=1, each bit of `clk_ddr` equals the matching bit of `reg_ddr` after reset, whatever the value of `pin_ddr`. Both vectors use the bit order of R2.
- R4: In single-rate mode, the nibble on `din` at a rising edge appears on `dout_a` after the next rising edge, with `vld_a`=1 and `vld_b`=0.
- R5: In double-rate mode, after a rising edge `dout_a` holds the nibble from the previous rising edge and `dout_b` holds the nibble from the falling edge between the two. Both strobes are 1.
- R6: Only `clk_ddr[1]` (transmit input) selects the sampling scheme. The receive and transmit-output modes have no effect on the data or the strobes.
- R7: With `swap`=1, bit i of each output nibble is bit 3-i of the captured nibble, and this holds in both modes. With `swap`=0 the nibble passes unchanged.
- R8: Changes on `pin_ddr`, `use_reg` or `reg_ddr` while out of reset change neither `clk_ddr` nor the sampling scheme until the next reset.
- R9: The first valid output after reset carries the nibble sampled on the first rising edge with `rst` low. No strobe is raised after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel bus clock; both edges are used in double-rate mode |
| rst | input | 1 | Synchronous reset, active high; the modes are latched while it is high |
| din | input | 4 | Parallel transmit data bus |
| pin_ddr | input | 1 | Global mode pin (1 = all clocks double-rate) |
| use_reg | input | 1 | Mode source select (0 = pin, 1 = per-clock bits) |
| reg_ddr | input | 3 | Per-clock double-rate enables {tx out, tx in, rx} |
| swap | input | 1 | Reverse the bit order of captured nibbles |
| clk_ddr | output | 3 | Latched per-clock modes {tx out, tx in, rx} |
| dout_a | output | 4 | Rising-edge nibble (the only lane in single-rate mode) |
| dout_b | output | 4 | Falling-edge nibble of the pair |
| vld_a | output | 1 | Strobe for dout_a |
| vld_b | output | 1 | Strobe for dout_b |

## Verification
The hardest case to reach is the mode control ignoring changes made while the block runs. The output must continue in its original scheme, and the latched mode vector must not move until a fresh reset. To reach it, the bench resets into single-rate mode and then flips the pin, the source select and the enable bits in the middle of a stream. It checks that every later word still carries one strobe and that the mode vector is unchanged. A second reset then confirms that the new settings are taken up. To test falling-edge pairing, the bench changes the bus shortly after each edge, so every rising and falling sample has a distinct value.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_SINGLE = 2'd1,
        ST_DOUBLE = 2'd2
    } cap_state_e;
endpackage

// File: rtl/mode_resolve.sv
module mode_resolve #(
    parameter int NCLK = 3
) (
    input  logic            pin_ddr,
    input  logic            use_reg,
    input  logic [NCLK-1:0] reg_ddr,
    output logic [NCLK-1:0] sel_ddr
);
    for (genvar i = 0; i < NCLK; i++) begin : g_sel
        assign sel_ddr[i] = use_reg ? reg_ddr[i] : pin_ddr;
    end
endmodule

// File: rtl/edge_sampler.sv
module edge_sampler #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise_q,
    output logic [W-1:0] fall_q
);
    always_ff @(posedge clk) begin
        rise_q <= din;
    end

    always_ff @(negedge clk) begin
        fall_q <= din;
    end
endmodule

// File: rtl/bit_reverse.sv
module bit_reverse #(
    parameter int W = 4
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] flipped;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign flipped[i] = din[W-1-i];
    end

    assign dout = en ? flipped : din;
endmodule

// File: rtl/sdr_ddr_capture.sv
module sdr_ddr_capture
    import cap_pkg::*;
#(
    parameter int W        = 4,
    parameter int NCLK     = 3,
    parameter int TXIN_IDX = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [W-1:0]    din,
    input  logic            pin_ddr,
    input  logic            use_reg,
    input  logic [NCLK-1:0] reg_ddr,
    input  logic            swap,
    output logic [NCLK-1:0] clk_ddr,
    output logic [W-1:0]    dout_a,
    output logic [W-1:0]    dout_b,
    output logic            vld_a,
    output logic            vld_b
);
    cap_state_e      state_q, state_d;
    logic [NCLK-1:0] sel_ddr;
    logic [NCLK-1:0] mode_q;
    logic [W-1:0]    rise_q, fall_q;
    logic [W-1:0]    rise_sw, fall_sw;

    mode_resolve #(.NCLK(NCLK)) u_mode (
        .pin_ddr (pin_ddr),
        .use_reg (use_reg),
        .reg_ddr (reg_ddr),
        .sel_ddr (sel_ddr)
    );

    edge_sampler #(.W(W)) u_samp (
        .clk    (clk),
        .din    (din),
        .rise_q (rise_q),
        .fall_q (fall_q)
    );

    bit_reverse #(.W(W)) u_rev_r (.en(swap), .din(rise_q), .dout(rise_sw));
    bit_reverse #(.W(W)) u_rev_f (.en(swap), .din(fall_q), .dout(fall_sw));

    // Mode latch: open only in reset or HOLD
    always_ff @(posedge clk) begin
        if (rst || state_q == ST_HOLD) begin
            mode_q <= sel_ddr;
        end
    end
    assign clk_ddr = mode_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_HOLD:   state_d = sel_ddr[TXIN_IDX] ? ST_DOUBLE : ST_SINGLE;
            ST_SINGLE: state_d = ST_SINGLE;
            ST_DOUBLE: state_d = ST_DOUBLE;
            default:   state_d = ST_HOLD;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            dout_a <= '0;
            dout_b <= '0;
            vld_a  <= 1'b0;
            vld_b  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_SINGLE: begin
                    dout_a <= rise_sw;
                    dout_b <= '0;
                    vld_a  <= 1'b1;
                    vld_b  <= 1'b0;
                end
                ST_DOUBLE: begin
                    dout_a <= rise_sw;
                    dout_b <= fall_sw;
                    vld_a  <= 1'b1;
                    vld_b  <= 1'b1;
                end
                default: begin
                    dout_a <= '0;
                    dout_b <= '0;
                    vld_a  <= 1'b0;
                    vld_b  <= 1'b0;
                end
            endcase
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!vld_a && !vld_b)); // R1
    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (rst) vld_b |-> vld_a); // R5
    AST_B_NEEDS_DDR: assert property (@(posedge clk) disable iff (rst) vld_b |-> clk_ddr[TXIN_IDX]); // R6
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_HOLD) |=> $stable(clk_ddr)); // R8
    AST_SINGLE_STREAM: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SINGLE) |=> (vld_a && !vld_b)); // R4
    AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD) |=> (!vld_a && !vld_b)); // R9
endmodule

// File: tb/tb_sdr_ddr_capture.sv
module tb_sdr_ddr_capture;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] din = 4'h0;
    logic       pin_ddr = 1'b0;
    logic       use_reg = 1'b0;
    logic [2:0] reg_ddr = 3'b000;
    logic       swap = 1'b0;
    logic [2:0] clk_ddr;
    logic [3:0] dout_a, dout_b;
    logic       vld_a, vld_b;

    int errors = 0;
    int checks = 0;
    logic [3:0] rv_seq [16];
    logic [3:0] fv_seq [16];

    always #10 clk = ~clk;

    sdr_ddr_capture dut (
        .clk(clk), .rst(rst), .din(din), .pin_ddr(pin_ddr), .use_reg(use_reg),
        .reg_ddr(reg_ddr), .swap(swap), .clk_ddr(clk_ddr), .dout_a(dout_a),
        .dout_b(dout_b), .vld_a(vld_a), .vld_b(vld_b)
    );

    function automatic logic [3:0] rv(input logic [3:0] v, input logic s);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = v[3-i];
        return s ? r : v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_modes(input logic [2:0] exp, input string req);
        check(clk_ddr == exp, req, {13'd0, clk_ddr}, {13'd0, exp});
    endtask

    // Starts at a falling edge right after reset release; checks n cycles
    task automatic run_stream(input int n, input bit ddr, input int seed, input string req,
                              input bit flip_cfg);
        for (int k = 0; k < n; k++) begin
            rv_seq[k] = 4'((k * 5 + seed) ^ 4'h9);
            fv_seq[k] = 4'((k * 3 + seed * 7) ^ 4'h6);
        end
        for (int k = 0; k < n; k++) begin
            #2 din = rv_seq[k];
            @(posedge clk);
            #2 din = fv_seq[k];
            if (flip_cfg && k == 2) begin
                pin_ddr = ~pin_ddr;
                use_reg = ~use_reg;
                reg_ddr = ~reg_ddr;
            end
            if (k == 0) begin
                check(!vld_a && !vld_b, "R9 no strobe on first edge", {14'd0, vld_a, vld_b}, 16'd0);
            end else if (ddr) begin
                check(vld_a && vld_b && dout_a == rv(rv_seq[k-1], swap) && dout_b == rv(fv_seq[k-1], swap),
                      req, {6'd0, vld_a, vld_b, dout_a, dout_b},
                      {6'd0, 2'b11, rv(rv_seq[k-1], swap), rv(fv_seq[k-1], swap)});
            end else begin
                check(vld_a && !vld_b && dout_a == rv(rv_seq[k-1], swap),
                      req, {6'd0, vld_a, vld_b, dout_a, 4'd0},
                      {6'd0, 2'b10, rv(rv_seq[k-1], swap), 4'd0});
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: strobes low during reset
        repeat (3) @(posedge clk);
        #2 check(!vld_a && !vld_b, "R1 reset quiet", {14'd0, vld_a, vld_b}, 16'd0);

        // R2 + R4 + R9: pin single-rate
        use_reg = 0; pin_ddr = 0; reg_ddr = 3'b111; swap = 0;
        do_reset();
        check_modes(3'b000, "R2 pin low");
        run_stream(10, 1'b0, 1, "R4 single-rate capture", 1'b0);

        // R1: reset asserted mid-stream
        rst = 1'b1;
        @(posedge clk);
        #2 check(!vld_a && !vld_b, "R1 reset mid-stream", {14'd0, vld_a, vld_b}, 16'd0);

        // R2 + R5: pin double-rate
        pin_ddr = 1; reg_ddr = 3'b000;
        do_reset();
        check_modes(3'b111, "R2 pin high");
        run_stream(10, 1'b1, 3, "R5 double-rate pair", 1'b0);

        // R3 + R6: register mode, tx-in single, others double
        use_reg = 1; pin_ddr = 1; reg_ddr = 3'b101;
        do_reset();
        check_modes(3'b101, "R3 reg bits 101");
        run_stream(8, 1'b0, 5, "R6 tx-in single despite rx/txout ddr", 1'b0);

        // R3 + R6: register mode, only tx-in double
        pin_ddr = 0; reg_ddr = 3'b010;
        do_reset();
        check_modes(3'b010, "R3 reg bits 010");
        run_stream(8, 1'b1, 7, "R6 tx-in double", 1'b0);

        // R7: swap in both modes
        swap = 1; reg_ddr = 3'b010;
        do_reset();
        run_stream(8, 1'b1, 9, "R7 swap double-rate", 1'b0);
        reg_ddr = 3'b000;
        do_reset();
        run_stream(8, 1'b0, 11, "R7 swap single-rate", 1'b0);
        swap = 0;

        // R8: configuration flipped while running is ignored
        use_reg = 0; pin_ddr = 0; reg_ddr = 3'b000;
        do_reset();
        run_stream(10, 1'b0, 13, "R8 mode unchanged while running", 1'b1);
        check_modes(3'b000, "R8 mode vector frozen");
        // now use_reg=1, reg_ddr=111: next reset takes it up
        do_reset();
        check_modes(3'b111, "R8 new mode after reset");
        run_stream(6, 1'b1, 15, "R8 double after reset", 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule